// File: doc/BRIEF.md
# Tear-Free Frame Base Register with Commit Interrupt

This block holds the start address of the frame buffer that a display DMA fetcher reads. Software can write a new address at any point during scanout. The write lands in a pending (shadow) register. The fetcher keeps using the active address until the timing generator pulses `frame_start`. On that pulse, and only if the shadow has been written since the last commit, the shadow is copied into the active register. Because the address never changes partway through a frame, the picture does not tear.

Each commit sets a single "update taken" status bit. That bit passes through an enable mask to form the `irq` output. Software clears the status by writing a one to a clear register. The register port is a plain single-cycle write strobe with a combinational read mux.

Register map (word index on `reg_addr`):

| Index | Register |
|---|---|
| 0 | pending base, read/write |
| 1 | active base, read-only |
| 2 | enable mask, bit 0 |
| 3 | raw status, bit 0 |
| 4 | masked status, bit 0 |
| 5 | clear, write-only |

Reads of index 5 and of indices 6 to 7 return zero.

Top module: `fb_base_shadow`

## Requirements
- R1: After reset, the pending base, active base, enable, raw status and masked status all read zero, `scan_base` is zero and `irq` is low.
- R2: A write to index 0 stores `reg_wdata` with bits 1:0 forced to zero, and a read of index 0 returns that value.
- R3: `scan_base` and index 1 change only in the cycle after a `frame_start` pulse. At that point they take the pending value.
- R4: When index 0 is written several times between two frame starts, only the last value written is committed.
- R5: A `frame_start` with no pending write since the previous commit leaves `scan_base` unchanged and does not set the raw status.
- R6: Raw status bit 0 becomes 1 in the same cycle that the active base takes the new value.
- R7: Masked status is raw status ANDed with enable bit 0, and `irq` is the OR of the masked bits. Writing 0 to index 2 masks the interrupt, and writing 1 enables it.
- R8: Writing 1 in bit 0 of index 5 clears raw status bit 0. Writing 0 there leaves the bit unchanged.
- R9: When a commit and a clear write fall in the same cycle, the raw status ends up set.
- R10: A write to index 0 in the same cycle as `frame_start` does not take part in that commit. The previous pending value is committed, and the new value waits for the next frame start.
- R11: Reads of index 5, index 6 and index 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| scan_base | output | 32 | Active frame base address for the fetcher |
| irq | output | 1 | Update-taken interrupt, level |

## Verification
The assertions assume that `frame_start` is a single-cycle pulse. They also assume that `reg_wr` is a one-cycle strobe sampled on the rising clock edge with stable address and data. The bench drives every input on the falling edge and drops the strobe and pulse one cycle later, so neither is ever held across two edges. The bench reads registers only while no write is in flight, so the read value reflects settled state.

// File: rtl/fb_base_shadow.sv
module fb_base_shadow #(
  parameter int AW = 32,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [RW-1:0] reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          frame_start,
  output logic [AW-1:0] scan_base,
  output logic          irq
);
  localparam logic [RW-1:0] A_PEND = RW'(0);
  localparam logic [RW-1:0] A_CUR  = RW'(1);
  localparam logic [RW-1:0] A_EN   = RW'(2);
  localparam logic [RW-1:0] A_RAW  = RW'(3);
  localparam logic [RW-1:0] A_MIS  = RW'(4);
  localparam logic [RW-1:0] A_CLR  = RW'(5);

  logic [AW-1:0] pend_q, cur_q;
  logic          dirty_q, en_q, raw_q;

  wire wr_pend = reg_wr && reg_addr == A_PEND;
  wire wr_en   = reg_wr && reg_addr == A_EN;
  wire wr_clr  = reg_wr && reg_addr == A_CLR && reg_wdata[0];
  wire commit  = frame_start && dirty_q;
  wire mis     = raw_q & en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      cur_q   <= '0;
      dirty_q <= 1'b0;
      en_q    <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      if (wr_pend) pend_q <= {reg_wdata[AW-1:2], 2'b00};
      if (commit)  cur_q  <= pend_q;
      if (wr_pend)          dirty_q <= 1'b1;
      else if (frame_start) dirty_q <= 1'b0;
      if (wr_en) en_q <= reg_wdata[0];
      if (commit)      raw_q <= 1'b1;
      else if (wr_clr) raw_q <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PEND:  reg_rdata = pend_q;
      A_CUR:   reg_rdata = cur_q;
      A_EN:    reg_rdata[0] = en_q;
      A_RAW:   reg_rdata[0] = raw_q;
      A_MIS:   reg_rdata[0] = mis;
      default: reg_rdata = '0;
    endcase
  end

  assign scan_base = cur_q;
  assign irq       = mis;

  p_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && dirty_q) |=> scan_base == $past(pend_q));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(scan_base));
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !dirty_q) |=> $stable(scan_base));
  p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && dirty_q) |=> raw_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !(frame_start && dirty_q)) |=> !raw_q);
  p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q && raw_q));
endmodule

// File: tb/fb_base_shadow_tb_top.sv
module fb_base_shadow_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        frame_start = 1'b0;
  logic [31:0] scan_base;
  logic        irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fb_base_shadow dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frame_start(frame_start),
    .scan_base(scan_base), .irq(irq)
  );

  // {wr, addr, data, frame_start, expected scan_base, expected irq}
  localparam int NV = 12;
  localparam logic [69:0] VEC [NV] = '{
    {1'b1, 3'd0, 32'h1000_0003, 1'b0, 32'h0000_0000, 1'b0},
    {1'b0, 3'd0, 32'h0000_0000, 1'b1, 32'h1000_0000, 1'b0},
    {1'b1, 3'd2, 32'h0000_0001, 1'b0, 32'h1000_0000, 1'b1},
    {1'b1, 3'd5, 32'h0000_0000, 1'b0, 32'h1000_0000, 1'b1},
    {1'b1, 3'd5, 32'h0000_0001, 1'b0, 32'h1000_0000, 1'b0},
    {1'b0, 3'd0, 32'h0000_0000, 1'b1, 32'h1000_0000, 1'b0},
    {1'b1, 3'd0, 32'h2000_0000, 1'b0, 32'h1000_0000, 1'b0},
    {1'b1, 3'd0, 32'h3000_0004, 1'b0, 32'h1000_0000, 1'b0},
    {1'b0, 3'd0, 32'h0000_0000, 1'b1, 32'h3000_0004, 1'b1},
    {1'b1, 3'd2, 32'h0000_0000, 1'b0, 32'h3000_0004, 1'b0},
    {1'b1, 3'd2, 32'h0000_0001, 1'b0, 32'h3000_0004, 1'b1},
    {1'b1, 3'd5, 32'h0000_0001, 1'b0, 32'h3000_0004, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input logic wr, input logic [2:0] a, input logic [31:0] d, input logic fs);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; frame_start = fs;
    @(negedge clk);
    reg_wr = 1'b0; frame_start = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset reg", v, 32'h0);
    end
    chk("R1 reset scan_base", scan_base, 32'h0);
    chk("R1 reset irq", {31'd0, irq}, 32'h0);
    rst_n = 1'b1;

    // Table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      tick(VEC[i][69], VEC[i][68:66], VEC[i][65:34], VEC[i][33]);
      chk("R3/R4/R5 scan_base", scan_base, VEC[i][32:1]);
      chk("R6/R7/R8 irq", {31'd0, irq}, {31'd0, VEC[i][0]});
    end

    // R2 alignment and readback
    tick(1'b1, 3'd0, 32'hABCD_EF13, 1'b0);
    rd(3'd0, v); chk("R2 pending readback", v, 32'hABCD_EF10);
    rd(3'd1, v); chk("R3 active unchanged", v, 32'h3000_0004);

    // R6 raw set with active base; R7 masked view
    tick(1'b1, 3'd2, 32'h0, 1'b0);
    tick(1'b0, 3'd0, 32'h0, 1'b1);
    rd(3'd1, v); chk("R6 active loaded", v, 32'hABCD_EF10);
    rd(3'd3, v); chk("R6 raw set", v, 32'h1);
    rd(3'd4, v); chk("R7 masked zero when disabled", v, 32'h0);
    chk("R7 irq low when disabled", {31'd0, irq}, 32'h0);

    // R9 set wins over clear
    tick(1'b1, 3'd5, 32'h1, 1'b0);
    rd(3'd3, v); chk("R8 raw cleared", v, 32'h0);
    tick(1'b1, 3'd0, 32'h0000_4000, 1'b0);
    tick(1'b1, 3'd5, 32'h1, 1'b1);
    rd(3'd3, v); chk("R9 set wins over clear", v, 32'h1);
    chk("R9 commit happened", scan_base, 32'h0000_4000);

    // R10 write coinciding with frame start
    tick(1'b1, 3'd5, 32'h1, 1'b0);
    tick(1'b1, 3'd0, 32'h0000_8000, 1'b0);
    tick(1'b1, 3'd0, 32'h0000_C000, 1'b1);
    chk("R10 old pending committed", scan_base, 32'h0000_8000);
    rd(3'd0, v); chk("R10 new value held", v, 32'h0000_C000);
    tick(1'b0, 3'd0, 32'h0, 1'b1);
    chk("R10 new value next frame", scan_base, 32'h0000_C000);

    // R11 unused and clear reads
    for (int a = 5; a < 8; a++) begin
      rd(3'(a), v);
      chk("R11 reads zero", v, 32'h0);
    end

    // R1 reset again clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset scan_base again", scan_base, 32'h0);
    rd(3'd3, v); chk("R1 reset raw again", v, 32'h0);
    rst_n = 1'b1;
    finish_run();
  end
endmodule